// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single column request into the per-beat column address stream of a synchronous DRAM burst. On a start strobe it captures a 9-bit start column, a burst-length code, a burst-order select and a read/write flag. From the next cycle it presents one column address per clock together with a valid flag. Fixed bursts of 2, 4 or 8 beats stay inside their aligned block and end on their own. A full-page burst walks the whole row and runs until it is stopped.

The block also watches the four active-low command pins for a burst-stop command. A stop cleanly ends a full-page burst. A stop during a fixed-length burst is reported as an illegal command and otherwise has no effect. For read bursts the block models the data-bus output enable. After a stop, that enable stays high for a number of clocks equal to the CAS latency and then drops to high impedance.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `illegal_cmd_o` and `dq_oe_o` are 0.
- R2: A start strobe sampled on a clock edge makes `valid_o` 1 and `col_o` equal to the captured start column in the following cycle. The length code is `blen_i`: 0 = 2 beats, 1 = 4 beats, 2 = 8 beats, 3 = full page. `ilv_i` 0 selects sequential order and 1 selects interleave order.
- R3: In sequential order with a fixed length BL, beat k keeps every column bit above the low log2(BL) bits. The low bits equal (start + k) mod BL, so no carry ever reaches a higher bit.
- R4: In interleave order with a fixed length, beat k equals the start column XOR k.
- R5: A fixed-length burst shows `valid_o` high for exactly BL consecutive cycles, then drops it without any further input.
- R6: A full-page burst increments the whole 9-bit column by one per beat, wraps from 511 to 0, and continues until it is stopped. `ilv_i` has no effect in full-page mode.
- R7: A burst-stop command is `cs_n_i`=0, `ras_n_i`=1, `cas_n_i`=1 and `we_n_i`=0, sampled on an edge. During a full-page burst it makes `valid_o` 0 from the next cycle. Any other pin pattern leaves the burst running.
- R8: A burst stop during a fixed-length burst raises `illegal_cmd_o` for exactly the next cycle, and the burst continues unchanged. A stop with no burst active raises nothing and changes nothing.
- R9: During a read burst `dq_oe_o` is 1. When a stop ends a full-page read, `dq_oe_o` stays 1 and falls on the CL-th clock edge after the stop edge. CL is `cas_lat_i` (2 or 3), sampled with the stop.
- R10: A start strobe during an active burst restarts the sequence from the new column in the next cycle. A start takes priority over a stop on the same edge.
- R11: During a write burst (`is_read_i`=0 at start) `dq_oe_o` stays 0, including after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 9 | Start column address |
| blen_i | input | 2 | Burst length code |
| ilv_i | input | 1 | Burst order: 0 sequential, 1 interleave |
| is_read_i | input | 1 | 1 marks the burst as a read |
| cas_lat_i | input | 2 | CAS latency (2 or 3) |
| cs_n_i | input | 1 | Chip select command pin, active low |
| ras_n_i | input | 1 | Row strobe command pin, active low |
| cas_n_i | input | 1 | Column strobe command pin, active low |
| we_n_i | input | 1 | Write enable command pin, active low |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | Beat valid |
| illegal_cmd_o | output | 1 | Stop issued during a fixed-length burst |
| dq_oe_o | output | 1 | Modelled data-bus output enable |

## Verification
Several properties are checked on every cycle. A restart always shows the new column on the next cycle. The bits above the burst block never move between beats of a sequential burst. A fixed burst drops valid after its last beat. A legal stop ends a full-page burst, and an illegal one is flagged while the burst continues. The output enable holds through the drain count. The address values themselves, the interleave order, the wrap at 511 and the exact clock on which the enable falls for each CAS latency can only be shown by the bench's scenarios. Those scenarios compare every cycle against an independent model.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    LEN_2    = 2'd0,
    LEN_4    = 2'd1,
    LEN_8    = 2'd2,
    LEN_PAGE = 2'd3
  } blen_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_BURST_STOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
endpackage

// File: rtl/bcg_cmd_decode.sv
module bcg_cmd_decode
  import bcg_pkg::*;
(
  input  cmd_pins_t pins_i,
  output logic      stop_o
);
  always_comb stop_o = (pins_i == CMD_BURST_STOP);
endmodule

// File: rtl/bcg_beat_seq.sv
module bcg_beat_seq
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  input  logic             rd_i,
  input  logic             stop_i,
  output logic             act_o,
  output logic             full_o,
  output logic             rd_act_o,
  output logic             stop_end_o,
  output logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] ONES = '1;

  function automatic logic [COL_W-1:0] burst_mask(blen_e b);
    case (b)
      LEN_2:   burst_mask = COL_W'(1);
      LEN_4:   burst_mask = COL_W'(3);
      LEN_8:   burst_mask = COL_W'(7);
      default: burst_mask = ONES;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] col_at(logic [COL_W-1:0] base, logic [COL_W-1:0] k,
                                              blen_e b, logic ilv);
    logic [COL_W-1:0] m;
    m = burst_mask(b);
    if (ilv && b != LEN_PAGE) col_at = base ^ (k & m);
    else                      col_at = (base & ~m) | ((base + k) & m);
  endfunction

  logic             act_q, ilv_q, rd_q;
  blen_e            blen_q;
  logic [COL_W-1:0] base_q, beat_q;

  logic evt_last, evt_stop_end, is_full;
  assign is_full      = (blen_q == LEN_PAGE);
  assign evt_last     = act_q && !is_full && (beat_q == burst_mask(blen_q));
  assign evt_stop_end = stop_i && act_q && is_full && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
      rd_q   <= 1'b0;
      blen_q <= LEN_2;
      base_q <= '0;
      beat_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      ilv_q  <= ilv_i;
      rd_q   <= rd_i;
      blen_q <= blen_e'(blen_i);
      base_q <= start_col_i;
      beat_q <= '0;
    end else if (act_q) begin
      if (evt_stop_end || evt_last) act_q <= 1'b0;
      else                          beat_q <= beat_q + 1'b1;
    end
  end

  assign act_o      = act_q;
  assign full_o     = is_full;
  assign rd_act_o   = act_q && rd_q;
  assign stop_end_o = evt_stop_end;
  assign col_o      = col_at(base_q, beat_q, blen_q, ilv_q);

  // R10 / R2: a start always presents the new column next cycle
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> act_o && col_o == $past(start_col_i));
  // R5: fixed burst ends by itself after its last beat
  p_fixed_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last && !start_i |=> !act_o);
  // R7: legal stop ends the full-page burst
  p_stop_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop_end |=> !act_o);
  // R3: bits above the burst block never change within a sequential burst
  p_upper_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !ilv_q && !start_i && !evt_last && !evt_stop_end
      |=> (col_o & ~burst_mask(blen_q)) == ($past(col_o) & ~burst_mask(blen_q)));
endmodule

// File: rtl/bcg_oe_drain.sv
module bcg_oe_drain #(
  parameter int CL_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_act_i,
  input  logic            stop_end_i,
  input  logic [CL_W-1:0] cas_lat_i,
  output logic            oe_o
);
  localparam logic [CL_W-1:0] ZERO = '0;

  logic [CL_W-1:0] drain_q;
  logic            draining;
  assign draining = (drain_q != ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           drain_q <= ZERO;
    else if (stop_end_i)  drain_q <= cas_lat_i;
    else if (draining)    drain_q <= drain_q - 1'b1;
  end

  assign oe_o = rd_act_i | draining;

  // R9: a stopped read keeps the bus driven right after the stop
  p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_end_i && rd_act_i && cas_lat_i != ZERO |=> oe_o);
  // R9: the last drain count releases the bus when no read is active
  p_drain_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q == CL_W'(1) && !stop_end_i && !rd_act_i |=> !oe_o || rd_act_i);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int CL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  input  logic             is_read_i,
  input  logic [CL_W-1:0]  cas_lat_i,
  input  logic             cs_n_i,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             we_n_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             illegal_cmd_o,
  output logic             dq_oe_o
);
  cmd_pins_t pins;
  logic      stop_cmd, act, full, rd_act, stop_end, bad_stop, illegal_q;

  assign pins = '{cs_n: cs_n_i, ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};

  bcg_cmd_decode u_dec (.pins_i(pins), .stop_o(stop_cmd));

  bcg_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .rd_i(is_read_i), .stop_i(stop_cmd),
    .act_o(act), .full_o(full), .rd_act_o(rd_act), .stop_end_o(stop_end), .col_o(col_o)
  );

  bcg_oe_drain #(.CL_W(CL_W)) u_oe (
    .clk(clk), .rst_n(rst_n), .rd_act_i(rd_act), .stop_end_i(stop_end && rd_act),
    .cas_lat_i(cas_lat_i), .oe_o(dq_oe_o)
  );

  assign bad_stop = stop_cmd && act && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= bad_stop;
  end

  assign valid_o       = act;
  assign illegal_cmd_o = illegal_q;

  // R8: a stop inside a fixed burst is flagged next cycle
  p_illegal_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd && valid_o && !full |=> illegal_cmd_o);
  // R8: the flag never appears without a stop during a fixed burst
  p_illegal_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_cmd && valid_o && !full) |=> !illegal_cmd_o);
  // R11: a write burst never drives the data bus
  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !is_read_i && !dq_oe_o |=> !dq_oe_o);
endmodule

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, ilv_i = 1'b0, is_read_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [1:0] blen_i = '0, cas_lat_i = 2'd2;
  logic       cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [8:0] col_o;
  logic       valid_o, illegal_cmd_o, dq_oe_o;

  always #2.5 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .is_read_i(is_read_i), .cas_lat_i(cas_lat_i),
    .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .col_o(col_o), .valid_o(valid_o), .illegal_cmd_o(illegal_cmd_o), .dq_oe_o(dq_oe_o)
  );

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] STOP = 4'b0110;
  localparam logic [3:0] ODD  = 4'b0101;

  int errors = 0, checks = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  // independent reference state
  logic       m_act = 0, m_full = 0, m_ilv = 0, m_rd = 0;
  logic [8:0] m_col0 = 0;
  int         m_k = 0, m_bl = 2, m_drain = 0;

  function automatic logic [8:0] ref_col();
    int base;
    if (m_full) return 9'((m_col0 + m_k) % 512);
    if (m_ilv)  return m_col0 ^ 9'(m_k);
    base = m_col0 - (m_col0 % m_bl);
    return 9'(base + ((m_col0 + m_k) % m_bl));
  endfunction

  task automatic cyc(input logic st, input logic [8:0] col, input logic [1:0] blc,
                     input logic il, input logic rd, input logic [3:0] cmd,
                     input logic [1:0] cl, input string tag);
    logic stopc, ill, oe;
    @(negedge clk);
    start_i = st; start_col_i = col; blen_i = blc; ilv_i = il; is_read_i = rd;
    cas_lat_i = cl; {cs_n_i, ras_n_i, cas_n_i, we_n_i} = cmd;
    stopc = (cmd == STOP);
    ill = stopc && m_act && !m_full;
    if (stopc && m_act && m_full && m_rd && !st) m_drain = int'(cl);
    else if (m_drain > 0) m_drain--;
    if (st) begin
      m_act = 1; m_k = 0; m_col0 = col; m_ilv = il; m_rd = rd;
      m_full = (blc == 2'd3); m_bl = 2 << blc;
    end else if (m_act) begin
      if (m_full && stopc) m_act = 0;
      else if (!m_full && m_k == m_bl - 1) m_act = 0;
      else m_k = (m_k + 1) % 512;
    end
    oe = (m_act && m_rd) || (m_drain > 0);
    exp_q.push_back({m_act, ref_col(), ill, oe});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 9'd0, 2'd0, 0, 0, NOP, 2'd2, tag);
  endtask

  task automatic run(input int n, input logic [3:0] cmd, input logic [1:0] cl, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 9'd0, 2'd0, 0, 0, cmd, cl, tag);
  endtask

  // monitor: pops one expected item per clock, right after the edge
  initial forever begin
    logic [11:0] e, a;
    string t;
    @(posedge clk); #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a = {valid_o, col_o, illegal_cmd_o, dq_oe_o};
      if (!e[11]) begin e[10:2] = '0; a[10:2] = '0; end
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: got valid=%b col=%h ill=%b oe=%b, expected valid=%b col=%h ill=%b oe=%b",
                 t, a[11], a[10:2], a[1], a[0], e[11], e[10:2], e[1], e[0]);
      end
    end
  end

  task automatic chk_reset(input logic v, input string name);
    checks++;
    if (v !== 1'b0) begin
      errors++;
      $display("FAIL R1 %s after reset: got %b expected 0", name, v);
    end
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset(valid_o, "valid_o");
    chk_reset(illegal_cmd_o, "illegal_cmd_o");
    chk_reset(dq_oe_o, "dq_oe_o");
    rst_n = 1'b1;
    idle(2, "R1 idle");
    // R2/R3 sequential BL4 from 0xA6: A6 A7 A4 A5
    cyc(1, 9'h0A6, 2'd1, 0, 0, NOP, 2'd2, "R2 R3 seq bl4");
    run(5, NOP, 2'd2, "R3 R5 seq bl4");
    // R3 BL8 near top of row: no carry above bit 2
    cyc(1, 9'h1FD, 2'd2, 0, 1, NOP, 2'd2, "R3 seq bl8");
    run(9, NOP, 2'd2, "R3 R5 R9 seq bl8 read");
    // R3 BL2
    cyc(1, 9'h011, 2'd0, 0, 0, NOP, 2'd2, "R3 seq bl2");
    run(3, NOP, 2'd2, "R3 R5 seq bl2");
    // R4 interleave BL8 and BL4
    cyc(1, 9'h05B, 2'd2, 1, 0, NOP, 2'd2, "R4 ilv bl8");
    run(9, NOP, 2'd2, "R4 R5 ilv bl8");
    cyc(1, 9'h102, 2'd1, 1, 0, NOP, 2'd2, "R4 ilv bl4");
    run(5, NOP, 2'd2, "R4 R5 ilv bl4");
    // R6/R7/R9 full-page read wrapping past 511, other cmd ignored, stop CL=3
    cyc(1, 9'h1FD, 2'd3, 1, 1, NOP, 2'd3, "R6 page read");
    run(4, NOP, 2'd3, "R6 wrap");
    run(1, ODD, 2'd3, "R7 non-stop cmd");
    run(1, STOP, 2'd3, "R7 R9 stop cl3");
    run(5, NOP, 2'd2, "R9 drain cl3");
    // full-page read, stop with CL=2
    cyc(1, 9'h040, 2'd3, 0, 1, NOP, 2'd2, "R6 page read2");
    run(2, NOP, 2'd2, "R6 page");
    run(1, STOP, 2'd2, "R7 R9 stop cl2");
    run(4, NOP, 2'd3, "R9 drain cl2");
    // R8 stop during fixed burst, then stop while idle
    cyc(1, 9'h0C4, 2'd2, 0, 0, NOP, 2'd2, "R8 bl8");
    run(2, NOP, 2'd2, "R8 bl8");
    run(1, STOP, 2'd2, "R8 illegal stop");
    run(6, NOP, 2'd2, "R8 burst continues");
    run(2, STOP, 2'd2, "R8 idle stop ignored");
    idle(1, "R8 idle");
    // R10 restart mid-burst, and start beats stop on the same edge
    cyc(1, 9'h010, 2'd2, 0, 0, NOP, 2'd2, "R10 first");
    run(2, NOP, 2'd2, "R10 first");
    cyc(1, 9'h0F3, 2'd1, 0, 0, NOP, 2'd2, "R10 restart");
    run(5, NOP, 2'd2, "R10 restarted");
    cyc(1, 9'h1F0, 2'd3, 0, 1, NOP, 2'd2, "R10 page");
    run(2, NOP, 2'd2, "R10 page");
    cyc(1, 9'h007, 2'd3, 0, 1, STOP, 2'd2, "R10 start over stop");
    run(2, NOP, 2'd2, "R10 page continues");
    run(1, STOP, 2'd2, "R7 stop");
    run(3, NOP, 2'd2, "R9 drain");
    // R11 write full page: no bus drive even after stop
    cyc(1, 9'h080, 2'd3, 0, 0, NOP, 2'd3, "R11 page write");
    run(3, NOP, 2'd3, "R11 write");
    run(1, STOP, 2'd3, "R11 stop");
    run(4, NOP, 2'd3, "R11 after stop");
    idle(3, "R1 final idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule